// File: doc/BRIEF.md
# SECDED Error Detection and Correction Unit

This unit protects a 16-bit data word with six check bits using an extended Hamming code. It corrects any single-bit error and detects any double-bit error. On a write the host presents the data word and takes the generated check bits, which are stored next to it. On a read the host presents the stored word together with its stored check bits. The unit then returns a syndrome, three error flags and the data word. Depending on the mode input, the returned data word is either passed through untouched or has a single-bit error repaired.

All results are registered. A strobe lets the host choose when the registers load, and the results appear one clock after the strobe. The same encoder network produces the write check bits and the recomputed parity for a read, so each strobe yields both `chk_o` for the presented data and the read results for the presented data and check pair.

Top module: `secded_edac`

## Requirements
- R1: Codeword positions 1..21 hold the check bits at positions 1, 2, 4, 8 and 16. Data bit j occupies the j-th position in 1..21 that is not a power of two, so bit 0 is at position 3 and bit 15 is at position 21. Check bit k, for k in 0..4, is the parity of every data bit whose position has bit k set. Check bit 5 is the parity of all data bits and of check bits 0..4, using their even-parity values.
- R2: Check bits 2 and 3 are stored inverted (odd parity) and the other four are even parity. An all-zero data word therefore yields check bits 6'b001100.
- R3: With mode_i = 0 (monitor), data_o equals the presented data_i whatever errors are found.
- R4: With mode_i = 1 (correct) and a single flipped data bit, data_o is the original error-free word. err_any_o = 1, and err_multi_o = err_dbl_o = 0.
- R5: A single flipped check bit sets only err_any_o and leaves data_o equal to data_i in both modes.
- R6: Any two flipped bits set err_any_o, err_multi_o and err_dbl_o. data_o equals data_i in both modes.
- R7: syn_o[4:0] is the XOR of the codeword positions of all flipped bits. syn_o[5] is 1 when an odd number of bits is flipped. A clean word gives syn_o = 0 and all flags 0.
- R8: An odd overall mismatch whose position syndrome is above 21 (an uncorrectable pattern) sets err_any_o and err_multi_o, clears err_dbl_o, and leaves data_o equal to data_i.
- R9: Outputs load one clock after en_i is high and hold their value while en_i is low.
- R10: While reset is asserted all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Load strobe for all result registers |
| mode_i | input | 1 | 0 = monitor only, 1 = always correct |
| data_i | input | 16 | Data word (write data or read data) |
| chk_i | input | 6 | Stored check bits for a read |
| chk_o | output | 6 | Check bits generated from data_i |
| data_o | output | 16 | Read data, corrected when mode_i = 1 |
| syn_o | output | 6 | Syndrome; bit 5 is the overall parity mismatch |
| err_any_o | output | 1 | Any error seen |
| err_multi_o | output | 1 | Uncorrectable error |
| err_dbl_o | output | 1 | Double-bit error |

## Verification
The assertions cover the following on every cycle:
- The flags are ordered: a double error implies an uncorrectable error, which implies some error.
- A double-error flag never appears with an odd syndrome.
- Monitor mode always passes the data through.
- Correct mode never changes more than one bit.
- The registers hold while the strobe is low.

The exact check-bit values, the inversion of check bits 2 and 3, the repaired word and the syndrome value for each flip pattern depend on the code itself. Only the bench's scenarios can show these. The bench encodes each word, injects chosen single, double and triple flips, and compares the results against a model built from the position rules.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned HAM_W  = 5;
  localparam int unsigned CHK_W  = HAM_W + 1;
  localparam int unsigned CW_TOP = DATA_W + HAM_W;
  // check bits stored with odd parity
  localparam logic [CHK_W-1:0] ODD_MASK = 6'b001100;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // codeword position of data bit idx
  function automatic int unsigned data_pos(input int unsigned idx);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned p = 1; p <= 2 * CW_TOP; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == idx && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // data bits covered by hamming check bit k
  function automatic logic [DATA_W-1:0] cover_mask(input int unsigned k);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned j = 0; j < DATA_W; j++)
      m[j] = ((data_pos(j) >> k) & 1) != 0;
    return m;
  endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W-1:0]  par_o,
  output logic              dpar_o
);
  for (genvar k = 0; k < HAM_W; k++) begin : g_par
    localparam logic [DATA_W-1:0] COVER = cover_mask(k);
    assign par_o[k] = ^(data_i & COVER);
  end
  assign dpar_o = ^data_i;
endmodule

// File: rtl/secded_classify.sv
module secded_classify
  import secded_pkg::*;
(
  input  logic [CHK_W-1:0]  syn_i,
  output logic [DATA_W-1:0] hit_o,
  output logic              single_o,
  output logic              any_o,
  output logic              multi_o,
  output logic              dbl_o
);
  logic [HAM_W-1:0] pos;
  logic             odd;
  logic             chk_hit;
  logic             invalid;

  assign pos = syn_i[HAM_W-1:0];
  assign odd = syn_i[CHK_W-1];

  for (genvar j = 0; j < DATA_W; j++) begin : g_hit
    localparam int unsigned P = data_pos(j);
    localparam logic [HAM_W-1:0] PV = P[HAM_W-1:0];
    assign hit_o[j] = (pos == PV);
  end

  always_comb begin
    chk_hit  = (pos == '0) || ($countones(pos) == 1);
    invalid  = odd && !chk_hit && !(|hit_o);
    single_o = odd && !invalid;
    dbl_o    = !odd && (pos != '0);
    multi_o  = dbl_o || invalid;
    any_o    = |syn_i;
  end
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] hit_i,
  input  logic              fix_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = data_i;
    if (fix_i) data_o = data_i ^ hit_i;
  end
endmodule

// File: rtl/secded_edac.sv
module secded_edac
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [15:0]       data_i,
  input  logic [5:0]        chk_i,
  output logic [5:0]        chk_o,
  output logic [15:0]       data_o,
  output logic [5:0]        syn_o,
  output logic              err_any_o,
  output logic              err_multi_o,
  output logic              err_dbl_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;

  logic [HAM_W-1:0]  par;
  logic              dpar;
  logic [CHK_W-1:0]  chk_eff;
  logic [CHK_W-1:0]  syn_d;
  logic [CHK_W-1:0]  gen_d;
  logic [DATA_W-1:0] hit;
  logic              single;
  logic              any_d, multi_d, dbl_d;
  logic [DATA_W-1:0] fixed_d;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  secded_encoder u_enc (
    .data_i (data_i),
    .par_o  (par),
    .dpar_o (dpar)
  );

  always_comb begin
    gen_d   = {dpar ^ (^par), par} ^ ODD_MASK;
    chk_eff = chk_i ^ ODD_MASK;
    syn_d   = {dpar ^ (^chk_eff), par ^ chk_eff[HAM_W-1:0]};
  end

  secded_classify u_cls (
    .syn_i    (syn_d),
    .hit_o    (hit),
    .single_o (single),
    .any_o    (any_d),
    .multi_o  (multi_d),
    .dbl_o    (dbl_d)
  );

  secded_corrector u_cor (
    .data_i (data_i),
    .hit_i  (hit),
    .fix_i  (single && mode_i),
    .data_o (fixed_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chk_o       <= '0;
      data_o      <= '0;
      syn_o       <= '0;
      err_any_o   <= 1'b0;
      err_multi_o <= 1'b0;
      err_dbl_o   <= 1'b0;
    end else if (en_i) begin
      chk_o       <= gen_d;
      data_o      <= fixed_d;
      syn_o       <= syn_d;
      err_any_o   <= any_d;
      err_multi_o <= multi_d;
      err_dbl_o   <= dbl_d;
    end
  end
endmodule

// File: rtl/secded_edac_chk.sv
module secded_edac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_i,
  input logic        mode_i,
  input logic [15:0] data_i,
  input logic [5:0]  chk_o,
  input logic [15:0] data_o,
  input logic [5:0]  syn_o,
  input logic        err_any_o,
  input logic        err_multi_o,
  input logic        err_dbl_o
);
  AST_DBL_IS_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    err_dbl_o |-> err_multi_o); // R6
  AST_MULTI_IS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    err_multi_o |-> err_any_o); // R8
  AST_DBL_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_dbl_o |-> !syn_o[5]); // R6
  AST_MONITOR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !mode_i && $past(rst_n)) |=> (data_o == $past(data_i))); // R3
  AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i && $past(rst_n)) |=> ($countones(data_o ^ $past(data_i)) <= 1)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(data_o) && $stable(syn_o) && $stable(chk_o)
               && $stable(err_any_o))); // R9
endmodule

bind secded_edac secded_edac_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .mode_i      (mode_i),
  .data_i      (data_i),
  .chk_o       (chk_o),
  .data_o      (data_o),
  .syn_o       (syn_o),
  .err_any_o   (err_any_o),
  .err_multi_o (err_multi_o),
  .err_dbl_o   (err_dbl_o)
);

// File: tb/test_secded_edac.sv
`timescale 1ns/1ps
module test_secded_edac;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_i, mode_i;
  logic [15:0] data_i;
  logic [5:0]  chk_i;
  logic [5:0]  chk_o, syn_o;
  logic [15:0] data_o;
  logic        err_any_o, err_multi_o, err_dbl_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  secded_edac i_secded_edac (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
    .data_i(data_i), .chk_i(chk_i), .chk_o(chk_o), .data_o(data_o),
    .syn_o(syn_o), .err_any_o(err_any_o), .err_multi_o(err_multi_o),
    .err_dbl_o(err_dbl_o)
  );

  // {mode, data, data flips, check flips}
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 16'hA5C3, 16'h0000, 6'b000000},
    {1'b0, 16'hA5C3, 16'h0000, 6'b000000},
    {1'b1, 16'h1234, 16'h0001, 6'b000000},
    {1'b1, 16'h1234, 16'h8000, 6'b000000},
    {1'b0, 16'h1234, 16'h0080, 6'b000000},
    {1'b1, 16'hFFFF, 16'h0200, 6'b000000},
    {1'b1, 16'h0000, 16'h0000, 6'b001000},
    {1'b1, 16'hBEEF, 16'h0000, 6'b100000},
    {1'b1, 16'h8001, 16'h8001, 6'b000000},
    {1'b0, 16'h5555, 16'h0008, 6'b000010},
    {1'b1, 16'h0F0F, 16'h0000, 6'b011100},
    {1'b1, 16'hFFFF, 16'h0000, 6'b000100},
    {1'b1, 16'h0001, 16'h0010, 6'b000000},
    {1'b0, 16'h0000, 16'h0000, 6'b000000}
  };

  function automatic int bpos(input int j);
    int cnt = 0;
    int r = 0;
    for (int p = 1; p <= 42; p++)
      if ((p & (p - 1)) != 0) begin
        if (cnt == j && r == 0) r = p;
        cnt++;
      end
    return r;
  endfunction

  function automatic logic [5:0] ref_chk(input logic [15:0] d);
    logic [4:0] raw = '0;
    for (int j = 0; j < 16; j++)
      if (d[j]) raw ^= bpos(j);
    return {(^d) ^ (^raw), raw} ^ 6'b001100;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic m, input logic [15:0] d, input logic [5:0] c);
    @(negedge clk);
    en_i = 1'b1; mode_i = m; data_i = d; chk_i = c;
    @(negedge clk);
    en_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_i = 1'b0; mode_i = 1'b0; data_i = '0; chk_i = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 data", data_o, 0);
    check("R10 flags", {chk_o, syn_o, err_any_o, err_multi_o, err_dbl_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: all-zero word
    strobe(1'b0, 16'h0000, 6'b000000);
    check("R2 zero word check bits", chk_o, 6'b001100);

    for (int v = 0; v < NV; v++) begin
      logic        m;
      logic [15:0] d, fd, dr, ed;
      logic [5:0]  fc, c, es;
      logic [4:0]  h;
      int          nf;
      logic        eany, emul, edbl;
      {m, d, fd, fc} = VEC[v];
      strobe(m, d, 6'b0);
      c = ref_chk(d);
      check("R1 check bits", chk_o, c);
      h  = '0;
      nf = $countones(fd) + $countones(fc);
      for (int j = 0; j < 16; j++) if (fd[j]) h ^= bpos(j);
      for (int k = 0; k < 5; k++)  if (fc[k]) h ^= 5'(1 << k);
      es   = {nf[0], h};
      eany = (es != 0);
      edbl = !es[5] && (h != 0);
      emul = edbl || (es[5] && h > 21);
      dr   = d ^ fd;
      ed   = dr;
      if (m && es[5])
        for (int j = 0; j < 16; j++) if (bpos(j) == h) ed[j] = ~ed[j];
      strobe(m, dr, c ^ fc);
      check("R7 syndrome", syn_o, es);
      if (nf == 2) check("R6 double flags", {err_any_o, err_multi_o, err_dbl_o}, 3'b111);
      else if (nf == 1 && fc != 0) check("R5 check-bit error flags", {err_any_o, err_multi_o, err_dbl_o}, 3'b100);
      else if (nf == 3) check("R8 invalid flags", {err_any_o, err_multi_o, err_dbl_o}, 3'b110);
      else check("R4 flags", {err_any_o, err_multi_o, err_dbl_o}, {eany, emul, edbl});
      if (!m) check("R3 monitor data", data_o, dr);
      else    check("R4 correct data", data_o, ed);
    end

    // R9: hold while strobe low
    strobe(1'b1, 16'h1234, ref_chk(16'h1234) ^ 6'b000011);
    @(negedge clk);
    data_i = 16'hFFFF; chk_i = 6'h3F; mode_i = 1'b0;
    @(negedge clk);
    check("R9 hold data", data_o, 16'h1234);
    check("R9 hold flags", {err_any_o, err_multi_o, err_dbl_o}, 3'b111);

    // R10: reset mid-run
    rst_n = 1'b0;
    #1;
    check("R10 async clear", {data_o, syn_o, err_any_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule